// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block holds the raw interrupt status of a UART. It takes single-cycle event pulses from the receiver (line errors, receive timeout), from the transmitter (end of transmission) and from the modem-line edge detectors. It also takes the fill counts of the transmit and receive FIFOs and compares them with programmable trigger levels. Each source sets one sticky bit in a ten-bit status word. Software clears a bit by writing a one to it through a separate write-one-to-clear port.

The transmit and receive bits also clear themselves when FIFO traffic moves the fill count back across the trigger point. The transmit bit has two meanings, chosen by a mode input: either the FIFO has drained to its trigger level, or the last bit has left the shifter. A mask input gives a masked status word and a single combined interrupt line. The interrupt line is registered and lags the masked status by one clock.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `raw_status`, `masked_status` and `irq` are all zero. The status word has a fixed layout: bit 9 break, bit 8 parity, bit 7 framing, bit 6 receive timeout, bit 5 transmit, bit 4 receive, bits 3..0 DSR, DCD, CTS, RI. `line_err_evt` is ordered {break, parity, framing} and `modem_evt` is ordered {DSR, DCD, CTS, RI}.
- R2: A pulse on a line-error, timeout or modem event input sets its status bit. The bit stays set, as seen at the ports, starting on the clock edge that samples the pulse.
- R3: When `clr_we` is high, each 1 in `clr_data` clears the status bit at the same position. Zeros in `clr_data`, or `clr_data` with `clr_we` low, leave every bit unchanged.
- R4: If a set and a clear (a written one or an auto-clear) reach the same bit in the same cycle, the bit ends up set.
- R5: With `fifo_en`=1 and `eot_mode`=0, the transmit bit sets when the condition `tx_fill` <= level changes from false to true. The level for selector values 0,1,2,3,4 is 2,4,8,12,14. Selector values 5 to 7 give level 8.
- R6: With `eot_mode`=1, the transmit bit sets only on `tx_done_evt`, and a fill crossing does not set it. With `eot_mode`=0, `tx_done_evt` is ignored.
- R7: The transmit bit clears itself on the cycle its FIFO condition changes from true to false, in both modes.
- R8: With `fifo_en`=1, the receive bit sets when the condition `rx_fill` >= level changes from false to true. It clears itself when that condition changes back to false. The levels are the same as in R5.
- R9: With `fifo_en`=0, the transmit condition is `tx_fill`==0 and the receive condition is `rx_fill`!=0. So a single pushed byte clears the transmit bit and a single popped byte clears the receive bit.
- R10: Status sets only on a rising edge of a condition. A FIFO condition that stays true does not set its bit again after a clear. A condition that is already true when reset ends does not set its bit.
- R11: Raw status bit 6 reads 0 while `mask[6]` is 0. The stored bit is kept and shows again when `mask[6]` returns to 1.
- R12: `masked_status` equals `raw_status` AND `mask`. `irq` equals the OR of `masked_status` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: FIFO trigger levels in use; 0: single-byte holding mode |
| eot_mode | input | 1 | 1: transmit bit marks end of transmission |
| tx_trig_sel | input | 3 | Transmit trigger level selector |
| rx_trig_sel | input | 3 | Receive trigger level selector |
| tx_fill | input | 5 | Transmit FIFO fill count (0..16) |
| rx_fill | input | 5 | Receive FIFO fill count (0..16) |
| tx_done_evt | input | 1 | Pulse: last bit has left the shifter |
| line_err_evt | input | 3 | Pulses {break, parity, framing} |
| rx_tmo_evt | input | 1 | Pulse: receive timeout |
| modem_evt | input | 4 | Pulses {DSR, DCD, CTS, RI} |
| clr_we | input | 1 | Write strobe of the clear port |
| clr_data | input | 10 | Write-one-to-clear data |
| mask | input | 10 | Interrupt mask |
| raw_status | output | 10 | Raw status word |
| masked_status | output | 10 | Raw status AND mask |
| irq | output | 1 | Registered OR of masked status |

## Verification
The bench pushes a set and a clear at the same bit in one cycle. A design that lets the clear win loses the event and reads 0 where 1 is expected. It holds a FIFO condition true across a clear and holds it through reset. A level-sensitive design would set the bit again and show a stray transmit or receive bit. It walks every trigger selector one count above and at the level, which exposes off-by-one comparisons and wrong fractions. It also covers the end-of-transmission mode, the FIFO-disabled single-byte rules, the hidden timeout bit and the one-cycle `irq` lag. Each of these would show up as a wrong bit or a wrong cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NBITS      = 10;
    localparam int FIFO_DEPTH = 16;
    localparam int FILL_W     = $clog2(FIFO_DEPTH + 1);
    localparam int SEL_W      = 3;

    // Bit positions are decoded by the clear port and by software
    localparam int IDX_RI  = 0;
    localparam int IDX_CTS = 1;
    localparam int IDX_DCD = 2;
    localparam int IDX_DSR = 3;
    localparam int IDX_RX  = 4;
    localparam int IDX_TX  = 5;
    localparam int IDX_TMO = 6;
    localparam int IDX_FRM = 7;
    localparam int IDX_PAR = 8;
    localparam int IDX_BRK = 9;

    typedef logic [NBITS-1:0] irq_vec_t;

    typedef enum logic [SEL_W-1:0] {
        TRIG_EIGHTH   = 3'd0,
        TRIG_QUARTER  = 3'd1,
        TRIG_HALF     = 3'd2,
        TRIG_3QUARTER = 3'd3,
        TRIG_7EIGHTH  = 3'd4
    } trig_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } cond_edge_t;

    function automatic logic [FILL_W-1:0] trig_level(input logic [SEL_W-1:0] sel, input int depth);
        case (trig_sel_e'(sel))
            TRIG_EIGHTH:   trig_level = FILL_W'(depth / 8);
            TRIG_QUARTER:  trig_level = FILL_W'(depth / 4);
            TRIG_HALF:     trig_level = FILL_W'(depth / 2);
            TRIG_3QUARTER: trig_level = FILL_W'((depth * 3) / 4);
            TRIG_7EIGHTH:  trig_level = FILL_W'((depth * 7) / 8);
            default:       trig_level = FILL_W'(depth / 2);
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_level_det.sv
module uart_irq_level_det
    import uart_irq_pkg::*;
#(
    parameter bit RX_SIDE = 1'b0,
    parameter int DEPTH   = FIFO_DEPTH,
    parameter int FW      = FILL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [FW-1:0]    fill,
    output cond_edge_t       edg
);
    logic [FW-1:0] lvl;
    logic          cond;
    logic          prev_q;

    assign lvl = FW'(trig_level(sel, DEPTH));

    generate
        if (RX_SIDE) begin : g_rx
            assign cond = fifo_en ? (fill >= lvl) : (fill != '0);
        end else begin : g_tx
            assign cond = fifo_en ? (fill <= lvl) : (fill == '0);
        end
    endgenerate

    // Reset to 1 so a condition already true at reset exit gives no edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= cond;
    end

    assign edg.rise = cond & ~prev_q;
    assign edg.fall = ~cond & prev_q;

    p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
        edg.rise |=> !edg.rise);
    p_fall_single_r7: assert property (@(posedge clk) disable iff (rst)
        edg.fall |=> !edg.fall);
endmodule

// File: rtl/uart_irq_sticky_bank.sv
module uart_irq_sticky_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] st
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)             bit_q <= 1'b0;
                else if (set_vec[i]) bit_q <= 1'b1;
                else if (clr_vec[i]) bit_q <= 1'b0;
            end
            assign st[i] = bit_q;

            p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> st[i]);
            p_clear_r3: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[i] && !set_vec[i]) |=> !st[i]);
            p_hold_r3: assert property (@(posedge clk) disable iff (rst)
                (!clr_vec[i] && !set_vec[i]) |=> $stable(st[i]));
        end
    endgenerate
endmodule

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int FW    = FILL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             eot_mode,
    input  logic [SEL_W-1:0] tx_trig_sel,
    input  logic [SEL_W-1:0] rx_trig_sel,
    input  logic [FW-1:0]    tx_fill,
    input  logic [FW-1:0]    rx_fill,
    input  logic             tx_done_evt,
    input  logic [2:0]       line_err_evt,
    input  logic             rx_tmo_evt,
    input  logic [3:0]       modem_evt,
    input  logic             clr_we,
    input  logic [NBITS-1:0] clr_data,
    input  logic [NBITS-1:0] mask,
    output logic [NBITS-1:0] raw_status,
    output logic [NBITS-1:0] masked_status,
    output logic             irq
);
    cond_edge_t tx_edge, rx_edge;
    irq_vec_t   set_vec, clr_vec, stat_q;
    logic       irq_q;

    uart_irq_level_det #(.RX_SIDE(1'b0), .DEPTH(DEPTH), .FW(FW)) u_tx_det (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .sel(tx_trig_sel),
        .fill(tx_fill), .edg(tx_edge));

    uart_irq_level_det #(.RX_SIDE(1'b1), .DEPTH(DEPTH), .FW(FW)) u_rx_det (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .sel(rx_trig_sel),
        .fill(rx_fill), .edg(rx_edge));

    always_comb begin
        set_vec                  = '0;
        set_vec[IDX_BRK:IDX_FRM] = line_err_evt;
        set_vec[IDX_TMO]         = rx_tmo_evt;
        set_vec[IDX_TX]          = eot_mode ? tx_done_evt : tx_edge.rise;
        set_vec[IDX_RX]          = rx_edge.rise;
        set_vec[IDX_DSR:IDX_RI]  = modem_evt;

        clr_vec          = clr_we ? clr_data : '0;
        clr_vec[IDX_TX]  = clr_vec[IDX_TX] | tx_edge.fall;
        clr_vec[IDX_RX]  = clr_vec[IDX_RX] | rx_edge.fall;
    end

    uart_irq_sticky_bank #(.N(NBITS)) u_bank (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .st(stat_q));

    always_comb begin
        raw_status          = stat_q;
        raw_status[IDX_TMO] = stat_q[IDX_TMO] & mask[IDX_TMO];
    end

    assign masked_status = raw_status & mask;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked_status;
    end
    assign irq = irq_q;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (raw_status == '0 && !irq));
    p_irq_latency_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|masked_status)));
    p_eot_ignores_level_r6: assert property (@(posedge clk) disable iff (rst)
        (eot_mode && !tx_done_evt && !stat_q[IDX_TX]) |=> !stat_q[IDX_TX]);
    p_err_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_q[IDX_BRK] && !(clr_we && clr_data[IDX_BRK])) |=> stat_q[IDX_BRK]);
endmodule

// File: tb/test_uart_irq_status_ctrl.sv
module test_uart_irq_status_ctrl;
    typedef struct packed {
        logic [23:0] tag;
        logic [9:0]  ev;
        logic        we;
        logic [9:0]  clr;
        logic [4:0]  txf;
        logic [4:0]  rxf;
        logic [9:0]  msk;
        logic [9:0]  exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{"R1 ", 10'h000, 1'b0, 10'h000, 5'd16, 5'd0, 10'h3FF, 10'h000},
        '{"R2 ", 10'h080, 1'b0, 10'h000, 5'd16, 5'd0, 10'h3FF, 10'h080},
        '{"R2 ", 10'h300, 1'b0, 10'h000, 5'd16, 5'd0, 10'h3FF, 10'h380},
        '{"R3 ", 10'h000, 1'b1, 10'h080, 5'd16, 5'd0, 10'h3FF, 10'h300},
        '{"R3 ", 10'h000, 1'b1, 10'h000, 5'd16, 5'd0, 10'h3FF, 10'h300},
        '{"R2 ", 10'h009, 1'b0, 10'h000, 5'd16, 5'd0, 10'h3FF, 10'h309},
        '{"R5 ", 10'h000, 1'b0, 10'h000, 5'd8,  5'd0, 10'h3FF, 10'h329},
        '{"R3 ", 10'h000, 1'b1, 10'h020, 5'd8,  5'd0, 10'h3FF, 10'h309},
        '{"R10", 10'h000, 1'b0, 10'h000, 5'd8,  5'd0, 10'h3FF, 10'h309},
        '{"R7 ", 10'h000, 1'b0, 10'h000, 5'd9,  5'd0, 10'h3FF, 10'h309},
        '{"R5 ", 10'h000, 1'b0, 10'h000, 5'd4,  5'd0, 10'h3FF, 10'h329},
        '{"R7 ", 10'h000, 1'b0, 10'h000, 5'd12, 5'd0, 10'h3FF, 10'h309},
        '{"R8 ", 10'h000, 1'b0, 10'h000, 5'd12, 5'd8, 10'h3FF, 10'h319},
        '{"R8 ", 10'h000, 1'b0, 10'h000, 5'd12, 5'd7, 10'h3FF, 10'h309},
        '{"R4 ", 10'h000, 1'b1, 10'h010, 5'd12, 5'd8, 10'h3FF, 10'h319},
        '{"R4 ", 10'h040, 1'b1, 10'h3FF, 5'd12, 5'd8, 10'h3FF, 10'h040},
        '{"R11", 10'h000, 1'b0, 10'h000, 5'd12, 5'd8, 10'h3BF, 10'h000},
        '{"R11", 10'h000, 1'b0, 10'h000, 5'd12, 5'd8, 10'h3FF, 10'h040},
        '{"R3 ", 10'h000, 1'b1, 10'h040, 5'd12, 5'd8, 10'h3FF, 10'h000},
        '{"R2 ", 10'h006, 1'b0, 10'h000, 5'd12, 5'd8, 10'h3FF, 10'h006}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1, eot_mode = 1'b0;
    logic [2:0] tx_trig_sel = 3'd2, rx_trig_sel = 3'd2;
    logic [4:0] tx_fill = 5'd16, rx_fill = 5'd0;
    logic       tx_done_evt = 1'b0, rx_tmo_evt = 1'b0, clr_we = 1'b0;
    logic [2:0] line_err_evt = '0;
    logic [3:0] modem_evt = '0;
    logic [9:0] clr_data = '0, mask = 10'h3FF;
    logic [9:0] raw_status, masked_status;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_irq_status_ctrl i_uart_irq_status_ctrl (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .eot_mode(eot_mode),
        .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
        .tx_fill(tx_fill), .rx_fill(rx_fill), .tx_done_evt(tx_done_evt),
        .line_err_evt(line_err_evt), .rx_tmo_evt(rx_tmo_evt), .modem_evt(modem_evt),
        .clr_we(clr_we), .clr_data(clr_data), .mask(mask),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq));

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_data = 10'h3FF;
        step();
        clr_we = 1'b0; clr_data = '0;
    endtask

    function automatic logic [4:0] exp_level(input int s);
        case (s)
            0: return 5'd2;
            1: return 5'd4;
            3: return 5'd12;
            4: return 5'd14;
            default: return 5'd8;
        endcase
    endfunction

    initial begin
        step(); step();
        chk(raw_status == '0 && masked_status == '0 && !irq, "R1 reset", raw_status, 10'h000);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            line_err_evt = TBL[k].ev[9:7];
            rx_tmo_evt   = TBL[k].ev[6];
            tx_done_evt  = TBL[k].ev[5];
            modem_evt    = TBL[k].ev[3:0];
            clr_we       = TBL[k].we;
            clr_data     = TBL[k].clr;
            tx_fill      = TBL[k].txf;
            rx_fill      = TBL[k].rxf;
            mask         = TBL[k].msk;
            step();
            chk(raw_status == TBL[k].exp, string'(TBL[k].tag), raw_status, TBL[k].exp);
            chk(masked_status == (TBL[k].exp & TBL[k].msk), "R12 masked", masked_status,
                TBL[k].exp & TBL[k].msk);
            line_err_evt = '0; rx_tmo_evt = 1'b0; tx_done_evt = 1'b0; modem_evt = '0;
            clr_we = 1'b0; clr_data = '0;
        end

        // R5 / R8: every trigger selector, one count off and at the level
        for (int s = 0; s < 8; s++) begin
            tx_trig_sel = 3'(s); rx_trig_sel = 3'(s);
            tx_fill = 5'd16; rx_fill = 5'd0;
            step(); clear_all();
            tx_fill = exp_level(s) + 5'd1; rx_fill = exp_level(s) - 5'd1;
            step();
            chk(raw_status[5:4] == 2'b00, "R5 R8 above/below level", raw_status, 10'h000);
            tx_fill = exp_level(s); rx_fill = exp_level(s);
            step();
            chk(raw_status[5:4] == 2'b11, "R5 R8 at level", raw_status, 10'h030);
        end
        tx_trig_sel = 3'd2; rx_trig_sel = 3'd2;

        // R6: end-of-transmission mode
        eot_mode = 1'b1; tx_fill = 5'd16; rx_fill = 5'd0;
        step(); clear_all();
        tx_fill = 5'd2;
        step();
        chk(raw_status[5] == 1'b0, "R6 level ignored", raw_status, 10'h000);
        tx_done_evt = 1'b1;
        step();
        tx_done_evt = 1'b0;
        chk(raw_status[5] == 1'b1, "R6 done sets", raw_status, 10'h020);
        eot_mode = 1'b0; tx_fill = 5'd16;
        step(); clear_all();
        tx_done_evt = 1'b1;
        step();
        tx_done_evt = 1'b0;
        chk(raw_status[5] == 1'b0, "R6 done ignored in level mode", raw_status, 10'h000);

        // R9: FIFOs disabled
        fifo_en = 1'b0; tx_fill = 5'd1; rx_fill = 5'd0;
        step(); clear_all();
        tx_fill = 5'd0;
        step();
        chk(raw_status[5] == 1'b1, "R9 tx empty sets", raw_status, 10'h020);
        tx_fill = 5'd1;
        step();
        chk(raw_status[5] == 1'b0, "R9 one push clears", raw_status, 10'h000);
        rx_fill = 5'd1;
        step();
        chk(raw_status[4] == 1'b1, "R9 rx byte sets", raw_status, 10'h010);
        rx_fill = 5'd0;
        step();
        chk(raw_status[4] == 1'b0, "R9 one pop clears", raw_status, 10'h000);

        // R12: irq lags masked status by one clock
        fifo_en = 1'b1; tx_fill = 5'd16; rx_fill = 5'd0;
        step(); clear_all();
        mask = 10'h002;
        step();
        modem_evt = 4'b0010;
        step();
        modem_evt = '0;
        chk(masked_status == 10'h002 && !irq, "R12 irq not yet", {9'd0, irq}, 10'h000);
        step();
        chk(irq == 1'b1, "R12 irq one cycle later", {9'd0, irq}, 10'h001);
        mask = 10'h000;
        #1;
        chk(masked_status == '0, "R12 mask off", masked_status, 10'h000);
        step();
        chk(irq == 1'b0, "R12 irq drops", {9'd0, irq}, 10'h000);
        mask = 10'h3FF;

        // R10: condition true through reset gives no set
        rst = 1'b1; rx_fill = 5'd16;
        step(); step();
        chk(raw_status == '0 && !irq, "R1 reset clears", raw_status, 10'h000);
        rst = 1'b0;
        step(); step(); step();
        chk(raw_status == '0, "R10 no set at reset exit", raw_status, 10'h000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule